// File: doc/BRIEF.md
# Restart Interrupt Unit

This block is the interrupt front end of a small 8-bit processor core. It watches five hardware request lines and picks the one to serve. One line cannot be masked and needs a rising edge. One is edge-latched. Two are level-sensitive. One is a general request that carries no vector of its own. When the core pulses its acknowledge strobe, the unit returns the 16-bit service address of the winner. If the general request wins, it asks for an opcode instead.

The core controls the unit in three ways:
- enable and disable commands for the global enable flag;
- a packed control byte that sets the masks, clears the edge latch and drives a one-bit serial output;
- a packed status byte, read back at any time.

Restart opcodes go through the same vector path. These come either from the software instruction stream or from a device that answered the opcode request. The unit turns each one into its fixed restart address.

Top module: `irq_restart_unit`

## Requirements
- R1: After reset the global enable flag is clear, all three level masks are 1, the edge latch is clear, `serialOut` is 0 and `intReq` is 0. With no requests and `serialIn` low, `statusByte` reads 07h.
- R2: A pulse on `enableCmd` sets the global enable flag, and a pulse on `disableCmd` clears it. If both arrive in the same cycle, the flag ends clear.
- R3: While the global enable flag is clear, the level, edge and general requests do not raise `intReq` and are not served. Only the non-maskable line can be served.
- R4: A control byte with bit 3 set loads bits 2..0 into the masks for levels 5.5, 6.5 and 7.5 in that bit order, where 1 means masked. With bit 3 clear, the masks keep their values.
- R5: A control byte with bit 4 set clears the level-7.5 edge latch.
- R6: A control byte with bit 6 set copies bit 7 to `serialOut`. With bit 6 clear, `serialOut` holds.
- R7: `statusByte` has the following layout:
  - bits 2..0: the masks;
  - bit 3: the global enable flag;
  - bit 4: the raw 5.5 request;
  - bit 5: the raw 6.5 request;
  - bit 6: the 7.5 latch;
  - bit 7: `serialIn`.
- R8: Priority runs from the non-maskable line, then 7.5, then 6.5, then 5.5, down to the general request. Masked levels are skipped.
- R9: An `ackStrobe` cycle with a serviceable source raises `vecValid` for exactly the next cycle. `vecAddr` is then 0024h for the non-maskable line, 003Ch for 7.5, 0034h for 6.5 and 002Ch for 5.5.
- R10: When the general request wins, `opcodeReq` pulses for one cycle in place of `vecValid`.
- R11: A `rstOpValid` cycle whose `rstOp` matches 11nnn111 raises `vecValid` on the next cycle with `vecAddr` = nnn*8. Any other opcode produces no output.
- R12: Level 7.5 is latched on a rising edge and stays pending after the line falls. Acknowledging it clears the latch. Levels 5.5 and 6.5 are pending only while high.
- R13: The non-maskable line is served after a rising edge, and only while it is still high. A steady high level does not make it pending again after it is acknowledged.
- R14: Accepting any source on `ackStrobe` clears the global enable flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| nmiReq | input | 1 | Non-maskable request, edge triggered and level qualified |
| lvl75Req | input | 1 | Level 7.5 request, rising-edge latched |
| lvl65Req | input | 1 | Level 6.5 request, level sensitive |
| lvl55Req | input | 1 | Level 5.5 request, level sensitive |
| genReq | input | 1 | General request with no built-in vector |
| enableCmd | input | 1 | Sets the global enable flag |
| disableCmd | input | 1 | Clears the global enable flag |
| maskWr | input | 1 | Writes the control byte |
| maskWrData | input | 8 | Control byte: masks, load enable, latch clear, serial enable and data |
| statusByte | output | 8 | Packed status byte |
| serialIn | input | 1 | Serial input pin, reflected in the status byte |
| serialOut | output | 1 | Serial output bit |
| ackStrobe | input | 1 | Acknowledge from the core |
| intReq | output | 1 | A serviceable source is pending |
| vecValid | output | 1 | One-cycle strobe qualifying `vecAddr` |
| vecAddr | output | 16 | Service address |
| opcodeReq | output | 1 | General request won; a restart opcode is needed |
| rstOpValid | input | 1 | Qualifies `rstOp` |
| rstOp | input | 8 | Restart opcode to translate |

## Verification
The assertions assume that all inputs are synchronous to `clk`. They also assume that `ackStrobe` and `rstOpValid` are never high in the same cycle; if they are, the acknowledge wins and the opcode is dropped. The stimulus keeps to these rules in four ways:
- It changes every input only on the falling edge.
- It pulses `ackStrobe` and `rstOpValid` in separate cycles.
- It raises each edge-sensitive line from a low level.
- It re-enables the unit before each acknowledge it expects to be served.

// File: rtl/irq_restart_pkg.sv
package irq_restart_pkg;

  localparam int VEC_W      = 16;
  localparam int NUM_LVL    = 3;
  localparam int SLOT_BYTES = 8;
  localparam int OP_W       = 8;

  // control byte fields
  localparam int CB_MASK_LO  = 0;
  localparam int CB_MASK_EN  = 3;
  localparam int CB_CLR75    = 4;
  localparam int CB_SER_EN   = 6;
  localparam int CB_SER_DATA = 7;

  // restart slots of the auto-vectored sources (address = slot*8 + 4)
  localparam int SLOT_NMI = 4;
  localparam int SLOT_L55 = 5;
  localparam int SLOT_L65 = 6;
  localparam int SLOT_L75 = 7;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_NMI, SRC_L75, SRC_L65, SRC_L55, SRC_GEN
  } src_e;

  typedef struct packed {
    logic               setEnable;
    logic               clrEnable;
    logic               loadMask;
    logic [NUM_LVL-1:0] maskVal;
    logic               clrLatch;
    logic               loadSerial;
    logic               serialVal;
    logic               clrNmi;
    logic               issueVec;
    logic               issueOpReq;
    logic [VEC_W-1:0]   vecAddr;
  } ctrlStrobe_t;

  function automatic logic [VEC_W-1:0] slotAddr(input int slot, input logic half);
    int a;
    a = slot * SLOT_BYTES + (half ? SLOT_BYTES / 2 : 0);
    return VEC_W'(a);
  endfunction

endpackage

// File: rtl/irq_restart_ctrl.sv
module irq_restart_ctrl
  import irq_restart_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               ackStrobe,
  input  logic               enableCmd,
  input  logic               disableCmd,
  input  logic               maskWr,
  input  logic [7:0]         maskWrData,
  input  logic               rstOpValid,
  input  logic [OP_W-1:0]    rstOp,
  input  logic               genReq,
  input  logic               lvl55Req,
  input  logic               lvl65Req,
  input  logic               enableFlag,
  input  logic [NUM_LVL-1:0] maskBits,
  input  logic               latch75,
  input  logic               nmiLive,
  output ctrlStrobe_t        strobe,
  output logic               intReq
);

  src_e winner;
  logic ackTaken;
  logic opMatch;
  logic [2:0] opSlot;
  logic unusedBit5;

  assign unusedBit5 = maskWrData[5];

  always_comb begin
    winner = SRC_NONE;
    if (nmiLive)                            winner = SRC_NMI;
    else if (enableFlag) begin
      if (latch75 && !maskBits[2])          winner = SRC_L75;
      else if (lvl65Req && !maskBits[1])    winner = SRC_L65;
      else if (lvl55Req && !maskBits[0])    winner = SRC_L55;
      else if (genReq)                      winner = SRC_GEN;
    end
  end

  assign intReq   = (winner != SRC_NONE);
  assign ackTaken = ackStrobe && intReq;

  assign opMatch = (rstOp[7:6] == 2'b11) && (rstOp[2:0] == 3'b111);
  assign opSlot  = rstOp[5:3];

  always_comb begin
    strobe            = '0;
    strobe.setEnable  = enableCmd;
    strobe.clrEnable  = disableCmd || ackTaken;
    strobe.loadMask   = maskWr && maskWrData[CB_MASK_EN];
    strobe.maskVal    = maskWrData[CB_MASK_LO +: NUM_LVL];
    strobe.clrLatch   = (maskWr && maskWrData[CB_CLR75]) || (ackTaken && winner == SRC_L75);
    strobe.loadSerial = maskWr && maskWrData[CB_SER_EN];
    strobe.serialVal  = maskWrData[CB_SER_DATA];
    strobe.clrNmi     = ackTaken && winner == SRC_NMI;
    if (ackTaken) begin
      strobe.issueVec   = (winner != SRC_GEN);
      strobe.issueOpReq = (winner == SRC_GEN);
      unique case (winner)
        SRC_NMI: strobe.vecAddr = slotAddr(SLOT_NMI, 1'b1);
        SRC_L75: strobe.vecAddr = slotAddr(SLOT_L75, 1'b1);
        SRC_L65: strobe.vecAddr = slotAddr(SLOT_L65, 1'b1);
        SRC_L55: strobe.vecAddr = slotAddr(SLOT_L55, 1'b1);
        default: strobe.vecAddr = '0;
      endcase
    end else if (rstOpValid && opMatch) begin
      strobe.issueVec = 1'b1;
      strobe.vecAddr  = slotAddr(int'(opSlot), 1'b0);
    end
  end

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!enableFlag && !nmiLive) |-> !intReq);  // R3
  AST_NMI_ALWAYS_SEEN: assert property (@(posedge clk) disable iff (!rstN)
    nmiLive |-> intReq);  // R13

endmodule

// File: rtl/irq_restart_dp.sv
module irq_restart_dp
  import irq_restart_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic               nmiReq,
  input  logic               lvl75Req,
  input  logic               lvl65Req,
  input  logic               lvl55Req,
  input  logic               serialIn,
  output logic               enableFlag,
  output logic [NUM_LVL-1:0] maskBits,
  output logic               latch75,
  output logic               nmiLive,
  output logic [7:0]         statusByte,
  output logic               serialOut,
  output logic               vecValid,
  output logic [VEC_W-1:0]   vecAddr,
  output logic               opcodeReq
);

  logic nmiPrev, nmiPend, l75Prev;
  logic [NUM_LVL-1:0] pendBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableFlag <= 1'b0;
      maskBits   <= '1;
      latch75    <= 1'b0;
      l75Prev    <= 1'b0;
      nmiPrev    <= 1'b0;
      nmiPend    <= 1'b0;
      serialOut  <= 1'b0;
    end else begin
      nmiPrev <= nmiReq;
      l75Prev <= lvl75Req;
      if (strobe.clrEnable)      enableFlag <= 1'b0;
      else if (strobe.setEnable) enableFlag <= 1'b1;
      if (strobe.loadMask)       maskBits <= strobe.maskVal;
      if (strobe.clrLatch)       latch75 <= 1'b0;
      else if (lvl75Req && !l75Prev) latch75 <= 1'b1;
      if (strobe.clrNmi || !nmiReq)  nmiPend <= 1'b0;
      else if (!nmiPrev)             nmiPend <= 1'b1;
      if (strobe.loadSerial)     serialOut <= strobe.serialVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecValid  <= 1'b0;
      opcodeReq <= 1'b0;
      vecAddr   <= '0;
    end else begin
      vecValid  <= strobe.issueVec;
      opcodeReq <= strobe.issueOpReq;
      if (strobe.issueVec) vecAddr <= strobe.vecAddr;
    end
  end

  assign nmiLive = nmiPend && nmiReq;

  // pending field: 5.5 and 6.5 raw, 7.5 from the latch
  generate
    for (genvar i = 0; i < NUM_LVL; i++) begin : g_pend
      if (i == NUM_LVL - 1) begin : g_edge
        assign pendBits[i] = latch75;
      end else if (i == 1) begin : g_l65
        assign pendBits[i] = lvl65Req;
      end else begin : g_l55
        assign pendBits[i] = lvl55Req;
      end
    end
  endgenerate

  assign statusByte = {serialIn, pendBits, enableFlag, maskBits};

  AST_LATCH_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrLatch |=> !latch75);  // R5
  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadMask |=> $stable(maskBits));  // R4
  AST_SINGLE_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({vecValid, opcodeReq}));  // R10
  AST_VEC_IN_TABLE: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> (vecAddr < VEC_W'(SLOT_BYTES * SLOT_BYTES)));  // R9

endmodule

// File: rtl/irq_restart_unit.sv
module irq_restart_unit
  import irq_restart_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             nmiReq,
  input  logic             lvl75Req,
  input  logic             lvl65Req,
  input  logic             lvl55Req,
  input  logic             genReq,
  input  logic             enableCmd,
  input  logic             disableCmd,
  input  logic             maskWr,
  input  logic [7:0]       maskWrData,
  output logic [7:0]       statusByte,
  input  logic             serialIn,
  output logic             serialOut,
  input  logic             ackStrobe,
  output logic             intReq,
  output logic             vecValid,
  output logic [VEC_W-1:0] vecAddr,
  output logic             opcodeReq,
  input  logic             rstOpValid,
  input  logic [OP_W-1:0]  rstOp
);

  ctrlStrobe_t        strobe;
  logic               enableFlag;
  logic [NUM_LVL-1:0] maskBits;
  logic               latch75;
  logic               nmiLive;

  irq_restart_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ackStrobe(ackStrobe), .enableCmd(enableCmd),
    .disableCmd(disableCmd), .maskWr(maskWr), .maskWrData(maskWrData),
    .rstOpValid(rstOpValid), .rstOp(rstOp), .genReq(genReq),
    .lvl55Req(lvl55Req), .lvl65Req(lvl65Req), .enableFlag(enableFlag),
    .maskBits(maskBits), .latch75(latch75), .nmiLive(nmiLive),
    .strobe(strobe), .intReq(intReq)
  );

  irq_restart_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .nmiReq(nmiReq),
    .lvl75Req(lvl75Req), .lvl65Req(lvl65Req), .lvl55Req(lvl55Req),
    .serialIn(serialIn), .enableFlag(enableFlag), .maskBits(maskBits),
    .latch75(latch75), .nmiLive(nmiLive), .statusByte(statusByte),
    .serialOut(serialOut), .vecValid(vecValid), .vecAddr(vecAddr),
    .opcodeReq(opcodeReq)
  );

  AST_ACCEPT_DISABLES: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && intReq) |=> !statusByte[3]);  // R14
  AST_ACK_ANSWERED: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && intReq) |=> (vecValid || opcodeReq));  // R9

endmodule

// File: tb/irq_restart_unit_tb.sv
module irq_restart_unit_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic nmiReq = 0, lvl75Req = 0, lvl65Req = 0, lvl55Req = 0, genReq = 0;
  logic enableCmd = 0, disableCmd = 0, maskWr = 0;
  logic [7:0] maskWrData = 0;
  logic [7:0] statusByte;
  logic serialIn = 0, serialOut;
  logic ackStrobe = 0, intReq, vecValid, opcodeReq;
  logic [15:0] vecAddr;
  logic rstOpValid = 0;
  logic [7:0] rstOp = 0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { bit isOp; logic [15:0] addr; string tag; } expItem_t;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  irq_restart_unit u_dut (
    .clk(clk), .rstN(rstN), .nmiReq(nmiReq), .lvl75Req(lvl75Req),
    .lvl65Req(lvl65Req), .lvl55Req(lvl55Req), .genReq(genReq),
    .enableCmd(enableCmd), .disableCmd(disableCmd), .maskWr(maskWr),
    .maskWrData(maskWrData), .statusByte(statusByte), .serialIn(serialIn),
    .serialOut(serialOut), .ackStrobe(ackStrobe), .intReq(intReq),
    .vecValid(vecValid), .vecAddr(vecAddr), .opcodeReq(opcodeReq),
    .rstOpValid(rstOpValid), .rstOp(rstOp)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // monitor: pops expected results as the design produces them
  always @(negedge clk) begin
    if (rstN && (vecValid || opcodeReq)) begin
      if (expQ.size() == 0) begin
        check("R11 unexpected output", {15'd0, vecValid}, 16'd0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check({e.tag, " kind"}, {15'd0, opcodeReq}, {15'd0, e.isOp});
        if (!e.isOp) check({e.tag, " vector"}, vecAddr, e.addr);
      end
    end
  end

  task automatic pulseEnable();
    enableCmd = 1; tick(); enableCmd = 0;
  endtask

  task automatic writeCtl(input logic [7:0] d);
    maskWr = 1; maskWrData = d; tick(); maskWr = 0; maskWrData = 0;
  endtask

  task automatic ackExpect(input bit isOp, input logic [15:0] a, input string tag);
    expQ.push_back('{isOp, a, tag});
    ackStrobe = 1; tick(); ackStrobe = 0;
  endtask

  task automatic opExpect(input logic [7:0] op, input logic [15:0] a, input string tag);
    expQ.push_back('{1'b0, a, tag});
    rstOpValid = 1; rstOp = op; tick(); rstOpValid = 0; rstOp = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check("watchdog", 16'd1, 16'd0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rstN = 1;
    tick();
    check("R1 status after reset", {8'd0, statusByte}, 16'h0007);
    check("R1 serialOut after reset", {15'd0, serialOut}, 16'd0);
    check("R1 intReq after reset", {15'd0, intReq}, 16'd0);

    // R3: unmasked level request ignored while disabled
    writeCtl(8'h08);
    lvl55Req = 1; tick();
    check("R3 disabled blocks level", {15'd0, intReq}, 16'd0);
    check("R7 status with 5.5 raw", {8'd0, statusByte}, 16'h0010);

    // R2 / R9 / R14
    pulseEnable();
    check("R2 enable flag set", {15'd0, statusByte[3]}, 16'd1);
    check("R3 enabled level served", {15'd0, intReq}, 16'd1);
    ackExpect(0, 16'h002C, "R9 level 5.5");
    check("R14 accept clears enable", {15'd0, statusByte[3]}, 16'd0);
    lvl55Req = 0;
    enableCmd = 1; disableCmd = 1; tick(); enableCmd = 0; disableCmd = 0;
    check("R2 disable wins", {15'd0, statusByte[3]}, 16'd0);

    // R8 priority walk
    pulseEnable();
    lvl55Req = 1; lvl65Req = 1; lvl75Req = 1; genReq = 1; tick();
    ackExpect(0, 16'h003C, "R8 7.5 highest level");
    check("R12 ack clears 7.5 latch", {15'd0, statusByte[6]}, 16'd0);
    pulseEnable();
    ackExpect(0, 16'h0034, "R8 6.5 over 5.5");
    pulseEnable();
    lvl65Req = 0; tick();
    check("R12 6.5 is level sensitive", {15'd0, statusByte[5]}, 16'd0);
    ackExpect(0, 16'h002C, "R8 5.5 over general");
    pulseEnable();
    lvl55Req = 0; tick();
    ackExpect(1, 16'h0000, "R10 general wants opcode");
    genReq = 0; lvl75Req = 0; tick();

    // R4 masking
    writeCtl(8'h0A);
    pulseEnable();
    lvl65Req = 1; lvl55Req = 1; tick();
    ackExpect(0, 16'h002C, "R8 masked 6.5 skipped");
    writeCtl(8'h05);
    check("R4 no load without bit 3", {13'd0, statusByte[2:0]}, 16'h0002);
    lvl65Req = 0; lvl55Req = 0;

    // R12 / R5 edge latch
    writeCtl(8'h08);
    lvl75Req = 1; tick(); lvl75Req = 0; tick();
    check("R12 7.5 latched after fall", {15'd0, statusByte[6]}, 16'd1);
    writeCtl(8'h10);
    check("R5 bit 4 clears latch", {15'd0, statusByte[6]}, 16'd0);
    check("R4 masks unchanged by clear", {13'd0, statusByte[2:0]}, 16'h0000);

    // R6 serial out, R7 serial in
    writeCtl(8'hC0);
    check("R6 serial set", {15'd0, serialOut}, 16'd1);
    writeCtl(8'h00);
    check("R6 serial held", {15'd0, serialOut}, 16'd1);
    writeCtl(8'h40);
    check("R6 serial cleared", {15'd0, serialOut}, 16'd0);
    serialIn = 1; #1;
    check("R7 serial in bit", {15'd0, statusByte[7]}, 16'd1);
    serialIn = 0;

    // R13 non-maskable
    nmiReq = 1; tick();
    check("R13 nmi pending while disabled", {15'd0, intReq}, 16'd1);
    ackExpect(0, 16'h0024, "R9 nmi vector");
    tick();
    check("R13 steady high no retrigger", {15'd0, intReq}, 16'd0);
    nmiReq = 0; tick();
    pulseEnable();
    lvl65Req = 1; nmiReq = 1; tick();
    ackExpect(0, 16'h0024, "R8 nmi over 6.5");
    lvl65Req = 0; nmiReq = 0; tick();
    nmiReq = 1; tick(); nmiReq = 0; tick();
    check("R13 nmi dropped before ack", {15'd0, intReq}, 16'd0);

    // R11 restart opcodes
    opExpect(8'hEF, 16'h0028, "R11 restart 5");
    opExpect(8'hC7, 16'h0000, "R11 restart 0");
    opExpect(8'hFF, 16'h0038, "R11 restart 7");
    rstOpValid = 1; rstOp = 8'hEE; tick(); rstOpValid = 0;
    check("R11 malformed opcode ignored", {15'd0, vecValid}, 16'd0);
    tick(); tick();
    check("R9 all results seen", 16'(expQ.size()), 16'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule